// File: doc/BRIEF.md
# Windowed Field Statistics Collector

This block watches a stream of video pixels and gathers scene measurements over one rectangular window of each field. The pixels arrive as luma and two offset-binary chroma components (red and blue difference), qualified by a valid strobe, with single-cycle line and field sync pulses. The block counts pixels along the line and lines down the field. For every valid pixel that lands inside the programmed window, it updates a running maximum of luma and three running sums: luma, red chroma and blue chroma.

When a field sync arrives, the running results move to a stable set of result registers and the running state clears. A one-cycle ready strobe then tells the host that fresh figures can be read. The block makes no decisions of its own. Exposure and white-balance loops belong to whatever reads the results. A plain write port sets the window edges, and a plain read port returns the results and the window settings.

Top module: `roi_stats`

## Requirements
- R1: After reset, all four result registers read zero and `stats_ready` is low. The window edges reset to horizontal 0..2047 and vertical 0..2047 (start 0, end all ones).
- R2: The pixel position is the number of valid pixels since the last `hsync` or `vsync`. The line number is the number of `hsync` pulses since the last `vsync`. Both counters stop at 2047 and do not wrap.
- R3: A pixel counts only when `pix_valid` is high and neither sync is high in that cycle. Its position must lie within start..end on both axes, with both ends inclusive. Any other input does not change the running results.
- R4: The peak result is the largest luma among the counted pixels of the field, or 0 if no pixel counted.
- R5: The luma sum is the unsigned total of the counted luma samples.
- R6: Each chroma sample is offset-binary. The block subtracts 128 from it and adds the result to a signed two's-complement sum: red at read address 2, blue at read address 3.
- R7: Every sum saturates at its limit and never wraps. The luma limit is 2^ACC_W-1. The chroma limits are -2^(ACC_W-1) and 2^(ACC_W-1)-1.
- R8: On the clock edge where `vsync` is high, the running peak and sums are copied to the result registers and then cleared. `stats_ready` is high for exactly the next cycle, and this happens after every `vsync`.
- R9: Between `vsync` pulses, the result registers do not change, whatever pixels arrive.
- R10: If the window lies wholly outside the active pixels, or a start value exceeds its end value, that field reports zero for all four results.
- R11: When `wr_en` is high, `wr_addr` selects the window edge to write: 0 horizontal start, 1 horizontal end, 2 vertical start, 3 vertical end. `rd_data` is combinational from `rd_addr`: 0 peak, 1 luma sum, 2 red sum, 3 blue sum, 4 to 7 the four edges in write order, each zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel strobe |
| hsync | input | 1 | Line start pulse |
| vsync | input | 1 | Field boundary pulse |
| luma | input | 8 | Luma sample |
| cr | input | 8 | Red chroma, offset-binary |
| cb | input | 8 | Blue chroma, offset-binary |
| wr_en | input | 1 | Window register write strobe |
| wr_addr | input | 2 | Window register select |
| wr_data | input | POS_W | Window edge value |
| rd_addr | input | 3 | Read select |
| rd_data | output | ACC_W | Read data |
| stats_ready | output | 1 | Fresh results pulse |

## Verification
The assertions assume that `vsync` is a single-cycle pulse and that a field always ends with one. They also assume that the window registers change only between fields, so the ready and hold properties relate to whole fields. The stimulus raises each sync for exactly one cycle. It writes the window only when the pipeline is idle and a `vsync` follows before any pixel it should affect. It still puts random valid pixels on sync cycles, to check that they are ignored.

// File: rtl/roi_stats_pkg.sv
package roi_stats_pkg;
  localparam int PIX_W      = 8;
  localparam int SMP_W      = PIX_W + 1;
  localparam int CHROMA_MID = 1 << (PIX_W - 1);
  localparam int N_SUMS     = 3;

  typedef enum logic [1:0] {
    WR_HSTART = 2'd0,
    WR_HEND   = 2'd1,
    WR_VSTART = 2'd2,
    WR_VEND   = 2'd3
  } wr_sel_e;

  typedef enum logic [2:0] {
    RD_PEAK   = 3'd0,
    RD_YSUM   = 3'd1,
    RD_CRSUM  = 3'd2,
    RD_CBSUM  = 3'd3,
    RD_HSTART = 3'd4,
    RD_HEND   = 3'd5,
    RD_VSTART = 3'd6,
    RD_VEND   = 3'd7
  } rd_sel_e;

  // offset-binary chroma to signed, mid code becomes zero
  function automatic logic signed [SMP_W-1:0] center_chroma(input logic [PIX_W-1:0] c);
    return $signed({1'b0, c}) - $signed(SMP_W'(CHROMA_MID));
  endfunction

  // luma as a non-negative sample of the common width
  function automatic logic signed [SMP_W-1:0] widen_luma(input logic [PIX_W-1:0] y);
    return $signed({1'b0, y});
  endfunction
endpackage

// File: rtl/roi_pos_tracker.sv
module roi_pos_tracker #(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             hsync,
  input  logic             vsync,
  input  logic [POS_W-1:0] h_start,
  input  logic [POS_W-1:0] h_end,
  input  logic [POS_W-1:0] v_start,
  input  logic [POS_W-1:0] v_end,
  output logic             in_win
);
  logic [POS_W-1:0] h_pos;
  logic [POS_W-1:0] v_pos;
  logic             pix_take;
  logic             h_inside;
  logic             v_inside;

  assign pix_take = pix_valid & ~hsync & ~vsync;
  assign h_inside = (h_pos >= h_start) && (h_pos <= h_end);
  assign v_inside = (v_pos >= v_start) && (v_pos <= v_end);
  assign in_win   = pix_take & h_inside & v_inside;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_pos <= '0;
      v_pos <= '0;
    end else if (vsync) begin
      h_pos <= '0;
      v_pos <= '0;
    end else if (hsync) begin
      h_pos <= '0;
      if (v_pos != '1) v_pos <= v_pos + 1'b1;
    end else if (pix_valid && h_pos != '1) begin
      h_pos <= h_pos + 1'b1;
    end
  end
endmodule

// File: rtl/roi_sat_accum.sv
module roi_sat_accum #(
  parameter int ACC_W     = 32,
  parameter int IN_W      = 9,
  parameter bit IS_SIGNED = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   add_en,
  input  logic signed [IN_W-1:0] sample,
  output logic [ACC_W-1:0]       acc,
  output logic                   sat_hit
);
  localparam int EXT_W = ACC_W + 1;

  logic [EXT_W-1:0] sum_ext;
  logic [ACC_W-1:0] acc_nxt;
  logic             ovf;

  generate
    if (IS_SIGNED) begin : g_signed
      always_comb begin
        sum_ext = {acc[ACC_W-1], acc} + {{(EXT_W-IN_W){sample[IN_W-1]}}, sample};
        ovf     = sum_ext[EXT_W-1] ^ sum_ext[EXT_W-2];
        if (!ovf)                 acc_nxt = sum_ext[ACC_W-1:0];
        else if (sum_ext[EXT_W-1]) acc_nxt = {1'b1, {(ACC_W-1){1'b0}}};
        else                      acc_nxt = {1'b0, {(ACC_W-1){1'b1}}};
      end
    end else begin : g_unsigned
      always_comb begin
        sum_ext = {1'b0, acc} + {{(EXT_W-IN_W){1'b0}}, sample};
        ovf     = sum_ext[EXT_W-1];
        acc_nxt = ovf ? '1 : sum_ext[ACC_W-1:0];
      end
    end
  endgenerate

  assign sat_hit = add_en & ovf;

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= '0;
    else if (clear)  acc <= '0;
    else if (add_en) acc <= acc_nxt;
  end
endmodule

// File: rtl/roi_peak_hold.sv
module roi_peak_hold #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd_en,
  input  logic [PIX_W-1:0] sample,
  output logic [PIX_W-1:0] peak
);
  logic higher;
  assign higher = sample > peak;

  always_ff @(posedge clk) begin
    if (!rst_n)                 peak <= '0;
    else if (clear)             peak <= '0;
    else if (upd_en && higher)  peak <= sample;
  end
endmodule

// File: rtl/roi_stats.sv
module roi_stats
  import roi_stats_pkg::*;
#(
  parameter int POS_W = 11,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             hsync,
  input  logic             vsync,
  input  logic [7:0]       luma,
  input  logic [7:0]       cr,
  input  logic [7:0]       cb,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [POS_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [ACC_W-1:0] rd_data,
  output logic             stats_ready
);
  localparam int PAD_POS  = ACC_W - POS_W;
  localparam int PAD_PEAK = ACC_W - PIX_W;

  logic [POS_W-1:0] win_hs, win_he, win_vs, win_ve;
  logic             in_win;
  logic [PIX_W-1:0] peak_run;
  logic [PIX_W-1:0] out_peak;
  logic signed [SMP_W-1:0] smp [N_SUMS];
  logic [ACC_W-1:0] acc_run [N_SUMS];
  logic [ACC_W-1:0] out_sum [N_SUMS];
  logic [N_SUMS-1:0] acc_sat;
  logic [ACC_W-1:0] luma_run;
  logic [ACC_W-1:0] out_luma;
  logic             luma_sat;

  // window edge registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_hs <= '0;
      win_he <= '1;
      win_vs <= '0;
      win_ve <= '1;
    end else if (wr_en) begin
      case (wr_sel_e'(wr_addr))
        WR_HSTART: win_hs <= wr_data;
        WR_HEND:   win_he <= wr_data;
        WR_VSTART: win_vs <= wr_data;
        default:   win_ve <= wr_data;
      endcase
    end
  end

  roi_pos_tracker #(.POS_W(POS_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .hsync     (hsync),
    .vsync     (vsync),
    .h_start   (win_hs),
    .h_end     (win_he),
    .v_start   (win_vs),
    .v_end     (win_ve),
    .in_win    (in_win)
  );

  roi_peak_hold #(.PIX_W(PIX_W)) u_peak (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (vsync),
    .upd_en (in_win),
    .sample (luma),
    .peak   (peak_run)
  );

  assign smp[0] = widen_luma(luma);
  assign smp[1] = center_chroma(cr);
  assign smp[2] = center_chroma(cb);

  generate
    for (genvar k = 0; k < N_SUMS; k++) begin : g_sum
      roi_sat_accum #(
        .ACC_W     (ACC_W),
        .IN_W      (SMP_W),
        .IS_SIGNED (k != 0)
      ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (vsync),
        .add_en  (in_win),
        .sample  (smp[k]),
        .acc     (acc_run[k]),
        .sat_hit (acc_sat[k])
      );

      always_ff @(posedge clk) begin
        if (!rst_n)     out_sum[k] <= '0;
        else if (vsync) out_sum[k] <= acc_run[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_peak    <= '0;
      stats_ready <= 1'b0;
    end else begin
      stats_ready <= vsync;
      if (vsync) out_peak <= peak_run;
    end
  end

  // named taps for the checker
  assign luma_run = acc_run[0];
  assign out_luma = out_sum[0];
  assign luma_sat = acc_sat[0];

  always_comb begin
    case (rd_sel_e'(rd_addr))
      RD_PEAK:   rd_data = {{PAD_PEAK{1'b0}}, out_peak};
      RD_YSUM:   rd_data = out_sum[0];
      RD_CRSUM:  rd_data = out_sum[1];
      RD_CBSUM:  rd_data = out_sum[2];
      RD_HSTART: rd_data = {{PAD_POS{1'b0}}, win_hs};
      RD_HEND:   rd_data = {{PAD_POS{1'b0}}, win_he};
      RD_VSTART: rd_data = {{PAD_POS{1'b0}}, win_vs};
      default:   rd_data = {{PAD_POS{1'b0}}, win_ve};
    endcase
  end
endmodule

// File: rtl/roi_stats_chk.sv
module roi_stats_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vsync,
  input logic             stats_ready,
  input logic             in_win,
  input logic [7:0]       peak_run,
  input logic [ACC_W-1:0] luma_run,
  input logic             luma_sat,
  input logic [7:0]       out_peak,
  input logic [ACC_W-1:0] out_luma
);
  AST_READY_AFTER_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> stats_ready); // R8
  AST_READY_ONLY_AFTER_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> !stats_ready); // R8
  AST_CLEARED_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    stats_ready |-> (peak_run == 8'd0 && luma_run == '0)); // R8
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> ($stable(out_peak) && $stable(out_luma))); // R9
  AST_OUTSIDE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_win && !vsync) |=> ($stable(luma_run) && $stable(peak_run))); // R3
  AST_PEAK_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> peak_run >= $past(peak_run)); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> luma_run >= $past(luma_run)); // R7
  AST_SAT_PINS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    luma_sat |=> luma_run == '1); // R7
endmodule

bind roi_stats roi_stats_chk #(.ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vsync       (vsync),
  .stats_ready (stats_ready),
  .in_win      (in_win),
  .peak_run    (peak_run),
  .luma_run    (luma_run),
  .luma_sat    (luma_sat),
  .out_peak    (out_peak),
  .out_luma    (out_luma)
);

// File: tb/roi_stats_bench.sv
module roi_stats_bench;
  localparam int CLK_PERIOD = 10;
  localparam int POS_W = 11;
  localparam int ACC_W = 20;
  localparam longint YMAX = (64'sd1 <<< ACC_W) - 1;
  localparam longint SMAX = (64'sd1 <<< (ACC_W - 1)) - 1;
  localparam longint SMIN = -(64'sd1 <<< (ACC_W - 1));
  localparam int PMAX = (1 << POS_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0, hsync = 1'b0, vsync = 1'b0;
  logic [7:0] luma = '0, cr = 8'd128, cb = 8'd128;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [POS_W-1:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [ACC_W-1:0] rd_data;
  logic stats_ready;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // bench model state
  int m_hs = 0, m_he = PMAX, m_vs = 0, m_ve = PMAX;
  int m_h = 0, m_v = 0;
  int m_peak = 0, o_peak = 0;
  longint m_y = 0, m_cr = 0, m_cb = 0;
  longint o_y = 0, o_cr = 0, o_cb = 0;
  bit exp_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  roi_stats #(.POS_W(POS_W), .ACC_W(ACC_W)) u_roi_stats (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .hsync(hsync), .vsync(vsync),
    .luma(luma), .cr(cr), .cb(cb), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .stats_ready(stats_ready)
  );

  function automatic longint clamp_u(input longint x);
    return (x > YMAX) ? YMAX : x;
  endfunction

  function automatic longint clamp_s(input longint x);
    if (x > SMAX) return SMAX;
    if (x < SMIN) return SMIN;
    return x;
  endfunction

  function automatic logic [ACC_W-1:0] to_bits(input longint x);
    logic [63:0] t;
    t = x;
    return t[ACC_W-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock of stimulus, with the model advanced as the requirements say
  task automatic step(input bit val, input bit hs, input bit vs,
                      input logic [7:0] y, input logic [7:0] r, input logic [7:0] b);
    @(negedge clk);
    check(stats_ready === exp_ready, "R8 stats_ready", stats_ready, exp_ready);
    pix_valid = val; hsync = hs; vsync = vs; luma = y; cr = r; cb = b;
    exp_ready = vs;
    if (vs) begin
      o_peak = m_peak; o_y = m_y; o_cr = m_cr; o_cb = m_cb;
      m_peak = 0; m_y = 0; m_cr = 0; m_cb = 0; m_h = 0; m_v = 0;
    end else if (hs) begin
      m_h = 0;
      if (m_v < PMAX) m_v++;
    end else if (val) begin
      if (m_h >= m_hs && m_h <= m_he && m_v >= m_vs && m_v <= m_ve) begin
        if (int'(y) > m_peak) m_peak = y;
        m_y  = clamp_u(m_y + y);
        m_cr = clamp_s(m_cr + (int'(r) - 128));
        m_cb = clamp_s(m_cb + (int'(b) - 128));
      end
      if (m_h < PMAX) m_h++;
    end
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 8'd0, 8'd128, 8'd128);
  endtask

  task automatic end_field();
    step($urandom_range(1), 1'b0, 1'b1, 8'($urandom), 8'($urandom), 8'($urandom));
    idle();
    idle();
  endtask

  task automatic write_win(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = POS_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      0: m_hs = d;
      1: m_he = d;
      2: m_vs = d;
      default: m_ve = d;
    endcase
    exp_ready = 1'b0;
  endtask

  task automatic read_chk(input int a, input longint exp, input string req);
    @(negedge clk);
    rd_addr = 3'(a);
    #1;
    check(rd_data === to_bits(exp), req, rd_data, exp);
    exp_ready = 1'b0;
  endtask

  task automatic check_results(input string req);
    read_chk(0, o_peak, {req, " peak"});
    read_chk(1, o_y,    {req, " luma sum"});
    read_chk(2, o_cr,   {req, " red sum"});
    read_chk(3, o_cb,   {req, " blue sum"});
  endtask

  // mode 0 random pixels, 1 all luma max / red max / blue min
  task automatic run_field(input int lines, input int ppl, input int mode);
    for (int l = 0; l < lines; l++) begin
      if (l > 0) step($urandom_range(1), 1'b1, 1'b0, 8'($urandom), 8'($urandom), 8'($urandom));
      for (int p = 0; p < ppl; p++) begin
        if (mode == 0 && $urandom_range(3) == 0) idle();
        if (mode == 0) step(1'b1, 1'b0, 1'b0, 8'($urandom), 8'($urandom), 8'($urandom));
        else           step(1'b1, 1'b0, 1'b0, 8'd255, 8'd255, 8'd0);
      end
    end
    end_field();
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(stats_ready === 1'b0, "R1 ready low", stats_ready, 0);
    check_results("R1 reset");
    read_chk(4, 0, "R1 hstart default");
    read_chk(5, PMAX, "R1 hend default");
    read_chk(6, 0, "R1 vstart default");
    read_chk(7, PMAX, "R1 vend default");

    // R11 write then read back
    write_win(0, 3); write_win(1, 17); write_win(2, 2); write_win(3, 9);
    read_chk(4, 3, "R11 hstart");
    read_chk(5, 17, "R11 hend");
    read_chk(6, 2, "R11 vstart");
    read_chk(7, 9, "R11 vend");

    // R3 R4 R5 R6 window subset, inclusive edges
    end_field();
    run_field(14, 24, 0);
    check_results("R3 R5 R6 subset window");

    // R9 outputs hold while another field streams in
    run_field_nohold: begin
      for (int p = 0; p < 300; p++)
        step(1'b1, (p % 30) == 29, 1'b0, 8'($urandom), 8'($urandom), 8'($urandom));
      check_results("R9 hold");
    end
    end_field();

    // random windows over several fields, full window first (R4 R5 R6)
    write_win(0, 0); write_win(1, PMAX); write_win(2, 0); write_win(3, PMAX);
    end_field();
    run_field(12, 30, 0);
    check_results("R4 R5 R6 full window");
    for (int f = 0; f < 6; f++) begin
      int a, b;
      a = $urandom_range(30); b = $urandom_range(30);
      write_win(0, (a < b) ? a : b); write_win(1, (a < b) ? b : a);
      a = $urandom_range(20); b = $urandom_range(20);
      write_win(2, (a < b) ? a : b); write_win(3, (a < b) ? b : a);
      end_field();
      run_field(10 + $urandom_range(12), 10 + $urandom_range(30), 0);
      check_results("R3 R4 R5 R6 random window");
    end

    // R10 window beyond active pixels, then start past end
    write_win(0, 1500); write_win(1, 1600); write_win(2, 0); write_win(3, PMAX);
    end_field();
    run_field(12, 30, 0);
    check(o_y == 0, "R10 model outside", o_y, 0);
    check_results("R10 outside");
    write_win(0, 0); write_win(1, PMAX); write_win(2, 10); write_win(3, 5);
    end_field();
    run_field(15, 20, 0);
    check_results("R10 inverted");

    // R2 horizontal counter stops at 2047: only positions >= 2047 land
    write_win(0, PMAX); write_win(1, PMAX); write_win(2, 0); write_win(3, 0);
    end_field();
    for (int p = 0; p < PMAX + 14; p++) step(1'b1, 1'b0, 1'b0, 8'd1, 8'd129, 8'd127);
    end_field();
    check(o_y == 14, "R2 model count", o_y, 14);
    check_results("R2 saturated position");

    // R7 saturation of all three sums
    write_win(0, 0); write_win(1, PMAX); write_win(2, 0); write_win(3, PMAX);
    end_field();
    run_field(80, 64, 1);
    check(o_y == YMAX && o_cr == SMAX && o_cb == SMIN, "R7 model clamp", o_y, YMAX);
    check_results("R7 saturation");

    // R8 clearing: an empty field after a full one reads zeros
    end_field();
    check_results("R8 cleared");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule